// File: doc/BRIEF.md
# Link Rate Selection Controller

This block decides at which data rate a serial link runs after training or retraining. It looks at the rates the local port can run, the rates the far end advertised, a rate ceiling written by software, and a ceiling imposed by hardware when the link proves unreliable at high rates. From these it picks the fastest rate that both ends share and that no ceiling forbids. It holds the result as the selected rate, and it raises a retrain request whenever that selection differs from the rate the link is running.

Power management can ask to slow the link without software involvement. Software can forbid these autonomous changes with a disable input. A separate control moves the link into compliance mode and back out. The rate the link runs at, and the compliance state, only change when the training logic reports completion with a one-cycle done pulse.

Rates are numbered from 1 upward: code 1 is 2.5 GT/s and code 2 is 5 GT/s. Capability vectors carry one bit per rate, with bit 0 for 2.5 GT/s and bit 1 for 5 GT/s. A ceiling value of 0 means "no limit".

Top module: `link_rate_selector`

## Requirements
- R1: After reset, `cur_speed` and `sel_speed` are 1, `retrain_req` is 0 and `compliance_mode` is 0.
- R2: With no ceiling active (software target at or above the top local rate, `hw_limit` 0, no autonomous cap), `sel_speed` is the highest code k for which bit k-1 is set in both `local_caps` and `partner_caps`.
- R3: When `sw_target` names a rate that the local port supports, `sel_speed` never exceeds it.
- R4: A `sw_target` of 0, above the number of rates, or naming a rate with a clear bit in `local_caps` acts as the highest rate set in `local_caps`. With `local_caps` all zero it acts as 1.
- R5: A nonzero `hw_limit` caps `sel_speed` at that code. A value of 0 removes the cap.
- R6: When no rate fits under the ceilings in the shared capability set, `sel_speed` is 1. `sel_speed` is always a code from 1 to the number of rates.
- R7: A `pm_req_valid` pulse with `auto_dis` low stores `pm_req_speed` as an autonomous cap, which takes effect from the following cycle. A stored value of 0 releases the cap.
- R8: While `auto_dis` is high, `pm_req_valid` pulses are ignored, and any stored autonomous cap is cleared at the next clock edge.
- R9: `cur_speed` changes only at the edge that samples `train_done` high, and it then takes the value `sel_speed` had in that cycle.
- R10: `retrain_req` is high exactly when `sel_speed` differs from `cur_speed`, or when `enter_compliance` differs from `compliance_mode`.
- R11: While `enter_compliance` is high, `sel_speed` equals the resolved software target of R4, and `partner_caps`, `hw_limit` and the autonomous cap are ignored. `compliance_mode` takes the value of `enter_compliance` at each `train_done` pulse.
- R12: `supported_speeds` always equals `local_caps`.
- R13: `sel_speed` is registered. It reflects the inputs one clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_caps | input | NUM_RATES | Rates this port can run, one bit per rate |
| partner_caps | input | NUM_RATES | Rates the far end advertised |
| sw_target | input | SPD_W | Software rate ceiling code |
| hw_limit | input | SPD_W | Reliability ceiling code, 0 = none |
| pm_req_valid | input | 1 | Autonomous rate-change request strobe |
| pm_req_speed | input | SPD_W | Requested autonomous cap, 0 = release |
| auto_dis | input | 1 | Forbids autonomous rate changes |
| enter_compliance | input | 1 | Requests compliance mode |
| train_done | input | 1 | One-cycle training completion pulse |
| supported_speeds | output | NUM_RATES | Capability field exposed to software |
| sel_speed | output | SPD_W | Rate chosen for the next training |
| cur_speed | output | SPD_W | Rate the link is currently running |
| retrain_req | output | 1 | Selection or compliance state differs from current |
| compliance_mode | output | 1 | Link is in compliance mode |

## Verification
The bench sweeps every combination of local capabilities, partner capabilities, software target and hardware limit. This exposes a design that returns 0 or a partner-only rate when the two ends share nothing. It also exposes one that trusts a target naming an unsupported rate, or one that lets a hardware limit of 0 act as a real ceiling. Separate sequences drive autonomous requests with the disable low and high. A design that latches a request while disabled, or keeps an old cap after the disable rises, would then pick too low a rate. The bench also checks that the current rate holds until the done pulse, and that compliance entry ignores the partner. A design that updated the current rate early would drop its retrain request too soon, and one that honoured the partner in compliance would pick 2.5 GT/s.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

  localparam int unsigned LRS_MAX_RATES = 16;

  // Highest rate code k (1-based) with vec[k-1] set and k <= ceil; 0 if none.
  function automatic int unsigned lrs_top_rate(logic [LRS_MAX_RATES-1:0] vec,
                                               int unsigned ceil);
    int unsigned best;
    best = 0;
    for (int unsigned k = 1; k <= LRS_MAX_RATES; k++) begin
      if (k <= ceil && vec[k-1]) best = k;
    end
    return best;
  endfunction

endpackage

// File: rtl/lrs_target_resolve.sv
module lrs_target_resolve
  import lrs_pkg::*;
#(
  parameter int unsigned NUM_RATES = 2,
  parameter int unsigned SPD_W     = $clog2(NUM_RATES + 1)
) (
  input  logic [NUM_RATES-1:0] local_caps,
  input  logic [SPD_W-1:0]     sw_target,
  output logic [SPD_W-1:0]     eff_target,
  output logic                 target_ok
);

  logic [LRS_MAX_RATES-1:0] caps_ext;
  int unsigned              top_local;

  assign caps_ext = LRS_MAX_RATES'(local_caps);

  always_comb begin
    target_ok = 1'b0;
    for (int unsigned k = 1; k <= NUM_RATES; k++) begin
      if (int'(sw_target) == int'(k) && local_caps[k-1]) target_ok = 1'b1;
    end
    top_local = lrs_top_rate(caps_ext, NUM_RATES);
    if (target_ok)          eff_target = sw_target;
    else if (top_local == 0) eff_target = SPD_W'(1);
    else                     eff_target = SPD_W'(top_local);
  end

endmodule

// File: rtl/lrs_auto_ctrl.sv
module lrs_auto_ctrl #(
  parameter int unsigned SPD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pm_req_valid,
  input  logic [SPD_W-1:0] pm_req_speed,
  input  logic             auto_dis,
  output logic [SPD_W-1:0] pm_cap
);

  logic [SPD_W-1:0] cap_q, cap_d;
  logic             cap_en;

  always_comb begin
    cap_en = auto_dis || pm_req_valid;
    cap_d  = auto_dis ? '0 : pm_req_speed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cap_d;
  end

  assign pm_cap = cap_q;

  // R8
  auto_dis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auto_dis |=> (pm_cap == '0));

  // R7
  pm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_dis && !pm_req_valid) |=> $stable(pm_cap));

endmodule

// File: rtl/lrs_rate_pick.sv
module lrs_rate_pick
  import lrs_pkg::*;
#(
  parameter int unsigned NUM_RATES = 2,
  parameter int unsigned SPD_W     = $clog2(NUM_RATES + 1)
) (
  input  logic [NUM_RATES-1:0] local_caps,
  input  logic [NUM_RATES-1:0] partner_caps,
  input  logic [SPD_W-1:0]     eff_target,
  input  logic [SPD_W-1:0]     hw_limit,
  input  logic [SPD_W-1:0]     pm_cap,
  input  logic                 comp_req,
  output logic [SPD_W-1:0]     pick
);

  logic [LRS_MAX_RATES-1:0] shared;
  logic [SPD_W-1:0]         ceil_v;
  int unsigned              found;

  assign shared = LRS_MAX_RATES'(local_caps & partner_caps);

  always_comb begin
    ceil_v = eff_target;
    if (hw_limit != '0 && hw_limit < ceil_v) ceil_v = hw_limit;
    if (pm_cap   != '0 && pm_cap   < ceil_v) ceil_v = pm_cap;
    found = lrs_top_rate(shared, int'(ceil_v));
    if (comp_req)        pick = eff_target;
    else if (found == 0) pick = SPD_W'(1);
    else                 pick = SPD_W'(found);
  end

endmodule

// File: rtl/link_rate_selector.sv
module link_rate_selector #(
  parameter int unsigned NUM_RATES = 2,
  parameter int unsigned SPD_W     = $clog2(NUM_RATES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] local_caps,
  input  logic [NUM_RATES-1:0] partner_caps,
  input  logic [SPD_W-1:0]     sw_target,
  input  logic [SPD_W-1:0]     hw_limit,
  input  logic                 pm_req_valid,
  input  logic [SPD_W-1:0]     pm_req_speed,
  input  logic                 auto_dis,
  input  logic                 enter_compliance,
  input  logic                 train_done,
  output logic [NUM_RATES-1:0] supported_speeds,
  output logic [SPD_W-1:0]     sel_speed,
  output logic [SPD_W-1:0]     cur_speed,
  output logic                 retrain_req,
  output logic                 compliance_mode
);

  localparam logic [SPD_W-1:0] LOWEST = SPD_W'(1);

  logic [SPD_W-1:0] eff_target, pm_cap, pick;
  logic             target_ok;
  logic [SPD_W-1:0] sel_q, cur_q, cur_d;
  logic             comp_q, comp_d;

  lrs_target_resolve #(.NUM_RATES(NUM_RATES), .SPD_W(SPD_W)) u_resolve (
    .local_caps (local_caps),
    .sw_target  (sw_target),
    .eff_target (eff_target),
    .target_ok  (target_ok)
  );

  lrs_auto_ctrl #(.SPD_W(SPD_W)) u_auto (
    .clk          (clk),
    .rst_n        (rst_n),
    .pm_req_valid (pm_req_valid),
    .pm_req_speed (pm_req_speed),
    .auto_dis     (auto_dis),
    .pm_cap       (pm_cap)
  );

  lrs_rate_pick #(.NUM_RATES(NUM_RATES), .SPD_W(SPD_W)) u_pick (
    .local_caps   (local_caps),
    .partner_caps (partner_caps),
    .eff_target   (eff_target),
    .hw_limit     (hw_limit),
    .pm_cap       (pm_cap),
    .comp_req     (enter_compliance),
    .pick         (pick)
  );

  // next-state
  always_comb begin
    cur_d  = train_done ? sel_q : cur_q;
    comp_d = train_done ? enter_compliance : comp_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= LOWEST;
      cur_q  <= LOWEST;
      comp_q <= 1'b0;
    end else begin
      sel_q  <= pick;
      cur_q  <= cur_d;
      comp_q <= comp_d;
    end
  end

  assign supported_speeds = local_caps;
  assign sel_speed        = sel_q;
  assign cur_speed        = cur_q;
  assign compliance_mode  = comp_q;
  assign retrain_req      = (sel_q != cur_q) || (enter_compliance != comp_q);

  // R9
  cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !train_done |=> $stable(cur_speed));

  // R9
  cur_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_done |=> (cur_speed == $past(sel_speed)));

  // R6
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_speed >= LOWEST) && (int'(sel_speed) <= int'(NUM_RATES)));

  // R3
  sw_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    target_ok |=> (sel_speed <= $past(sw_target)));

  // R11
  comp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    train_done |=> (compliance_mode == $past(enter_compliance)));

endmodule

// File: tb/tb_link_rate_selector.sv
`timescale 1ns/1ps
module tb_link_rate_selector;

  localparam int NUM_RATES = 2;
  localparam int SPD_W     = 2;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NUM_RATES-1:0] local_caps, partner_caps;
  logic [SPD_W-1:0]     sw_target, hw_limit, pm_req_speed;
  logic                 pm_req_valid, auto_dis, enter_compliance, train_done;
  logic [NUM_RATES-1:0] supported_speeds;
  logic [SPD_W-1:0]     sel_speed, cur_speed;
  logic                 retrain_req, compliance_mode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  link_rate_selector #(.NUM_RATES(NUM_RATES), .SPD_W(SPD_W)) dut (
    .clk(clk), .rst_n(rst_n), .local_caps(local_caps), .partner_caps(partner_caps),
    .sw_target(sw_target), .hw_limit(hw_limit), .pm_req_valid(pm_req_valid),
    .pm_req_speed(pm_req_speed), .auto_dis(auto_dis),
    .enter_compliance(enter_compliance), .train_done(train_done),
    .supported_speeds(supported_speeds), .sel_speed(sel_speed),
    .cur_speed(cur_speed), .retrain_req(retrain_req),
    .compliance_mode(compliance_mode)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_speed(int lc, int pc, int sw, int hw, int pm, int comp);
    int top = 0;
    int tgt, lim, best;
    for (int k = 1; k <= NUM_RATES; k++) if (((lc >> (k - 1)) & 1) == 1) top = k;
    if (sw >= 1 && sw <= NUM_RATES && ((lc >> (sw - 1)) & 1) == 1) tgt = sw;
    else tgt = (top == 0) ? 1 : top;
    if (comp != 0) return tgt;
    lim = tgt;
    if (hw != 0 && hw < lim) lim = hw;
    if (pm != 0 && pm < lim) lim = pm;
    best = 1;
    for (int k = 1; k <= lim; k++) if ((((lc & pc) >> (k - 1)) & 1) == 1) best = k;
    return best;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_done();
    train_done = 1'b1;
    tick();
    train_done = 1'b0;
  endtask

  task automatic pm_request(int spd);
    pm_req_valid = 1'b1;
    pm_req_speed = SPD_W'(spd);
    tick();
    pm_req_valid = 1'b0;
    tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    local_caps = '0; partner_caps = '0; sw_target = '0; hw_limit = '0;
    pm_req_valid = 1'b0; pm_req_speed = '0; auto_dis = 1'b0;
    enter_compliance = 1'b0; train_done = 1'b0;
    tick(); tick();
    // R1 reset state
    chk("R1 cur", int'(cur_speed), 1);
    chk("R1 sel", int'(sel_speed), 1);
    chk("R1 retrain", int'(retrain_req), 0);
    chk("R1 compliance", int'(compliance_mode), 0);
    rst_n = 1'b1;
    tick();

    // R2 R3 R4 R5 R6 R10 R12 R13: full sweep, no train_done so cur stays 1
    for (int lc = 0; lc < 4; lc++)
      for (int pc = 0; pc < 4; pc++)
        for (int sw = 0; sw < 4; sw++)
          for (int hw = 0; hw < 4; hw++) begin
            int e;
            local_caps = NUM_RATES'(lc); partner_caps = NUM_RATES'(pc);
            sw_target = SPD_W'(sw); hw_limit = SPD_W'(hw);
            tick();
            e = ref_speed(lc, pc, sw, hw, 0, 0);
            chk("R2/R3/R4/R5/R6 sel", int'(sel_speed), e);
            chk("R10 retrain", int'(retrain_req), (e != 1) ? 1 : 0);
            chk("R12 caps", int'(supported_speeds), lc);
            chk("R9 cur held", int'(cur_speed), 1);
          end

    // R9: load current rate on done pulse
    local_caps = 2'b11; partner_caps = 2'b11; sw_target = 2; hw_limit = 0;
    tick();
    chk("R13 sel", int'(sel_speed), 2);
    chk("R9 cur before done", int'(cur_speed), 1);
    chk("R10 retrain before done", int'(retrain_req), 1);
    pulse_done();
    chk("R9 cur after done", int'(cur_speed), 2);
    chk("R10 retrain after done", int'(retrain_req), 0);

    // R7: autonomous cap and release
    pm_request(1);
    chk("R7 pm cap", int'(sel_speed), 1);
    chk("R10 retrain on pm", int'(retrain_req), 1);
    pm_request(0);
    chk("R7 pm release", int'(sel_speed), 2);

    // R8: disable clears stored cap and ignores requests
    pm_request(1);
    chk("R7 pm cap again", int'(sel_speed), 1);
    auto_dis = 1'b1;
    tick(); tick();
    chk("R8 cap cleared", int'(sel_speed), 2);
    pm_request(1);
    chk("R8 request ignored", int'(sel_speed), 2);
    auto_dis = 1'b0;
    tick(); tick();
    chk("R8 still no cap", int'(sel_speed), 2);

    // R11: compliance ignores partner and limits
    partner_caps = 2'b01; hw_limit = 1;
    tick();
    chk("R5 limited", int'(sel_speed), 1);
    enter_compliance = 1'b1;
    tick();
    chk("R11 comp sel", int'(sel_speed), 2);
    chk("R10 comp retrain", int'(retrain_req), 1);
    chk("R11 mode before done", int'(compliance_mode), 0);
    pulse_done();
    chk("R11 mode after done", int'(compliance_mode), 1);
    chk("R9 cur comp", int'(cur_speed), 2);
    chk("R10 settled", int'(retrain_req), 0);
    enter_compliance = 1'b0;
    tick();
    chk("R11 exit sel", int'(sel_speed), 1);
    chk("R10 exit retrain", int'(retrain_req), 1);
    pulse_done();
    chk("R11 mode cleared", int'(compliance_mode), 0);
    chk("R9 cur after exit", int'(cur_speed), 1);
    chk("R10 exit settled", int'(retrain_req), 0);

    finish_run();
  end

endmodule